// File: doc/BRIEF.md
# Effective Address Qualifier

This block is the first stage of a two-level radix address translator. When a request strobe arrives, it looks at the effective address, the access kind, the hypervisor mode bit, the relocation enable and the current partition and process identifier registers. From these it decides which of three outcomes applies:

- a qualified pair of (partition ID, process ID) to be handed to the table walkers;
- a segment fault, with the faulting address captured for data accesses;
- a real-mode bypass address that needs no translation at all.

For a qualified request it also tells the later stages whether the process-scoped walk and the partition-scoped walk have to run. Every output is registered, so the result appears with a one-cycle done pulse. The outputs then hold their values until the next request.

The two most significant address bits form the quadrant. The bits between the quadrant and the implemented address range are a reserved field. The width of the implemented range is a parameter.

Top module: `ea_qualifier`

## Requirements
- R1: While reset is held and until the first request, every output is zero, including done.
- R2: A request strobe sampled on a clock edge gives `done_o` high for exactly the following cycle. Between requests, all result outputs hold their values whatever the inputs do.
- R3: Outside real-mode bypass, a nonzero bit anywhere in the reserved field (address bits EA_W-3 down to VA_BITS) gives a segment fault.
- R4: In hypervisor mode the quadrant (address bits EA_W-1:EA_W-2) selects the (partition, process) pair as follows: 0 gives (0, PID), 1 gives (LPID, PID), 2 gives (LPID, 0) and 3 gives (0, 0).
- R5: In guest mode, quadrant 0 gives (LPID, PID) and quadrant 3 gives (LPID, 0). Quadrants 1 and 2 give a segment fault.
- R6: The access code 2'b10 is an instruction fetch; any other code is a data access. A fault on a fetch raises `iseg_o`. A fault on a data access raises `dseg_o` and copies the effective address to `fault_addr_o`, which is zero otherwise.
- R7: With hypervisor mode on and relocation off, `bypass_o` is set and `raddr_o` equals the effective address with its top four bits cleared. When address bit EA_W-1 is clear, the offset register is also ORed in. The reserved field and the quadrant are not checked. In every other case `raddr_o` is zero.
- R8: `perm_o` (bit 2 read, bit 1 write, bit 0 execute) is 3'b111 for a bypass and 3'b000 otherwise.
- R9: `proc_run_o` is set exactly when the request is qualified and relocation is on.
- R10: `part_run_o` is set exactly when the request is qualified and either the chosen partition ID is nonzero or the mode is guest.
- R11: At most one of fault, bypass and qualified holds. When a fault or a bypass is flagged, both IDs and both run flags read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Single-cycle request strobe |
| ea_i | input | EA_W | Effective address |
| acc_i | input | 2 | Access kind: 2'b10 fetch, otherwise data |
| hv_i | input | 1 | Hypervisor mode |
| reloc_i | input | 1 | Relocation enable |
| lpid_reg_i | input | LPID_W | Current partition ID register |
| pid_reg_i | input | PID_W | Current process ID register |
| rmor_i | input | EA_W | Real-mode offset register |
| done_o | output | 1 | Result valid pulse |
| lpid_o | output | LPID_W | Qualified partition ID |
| pid_o | output | PID_W | Qualified process ID |
| iseg_o | output | 1 | Instruction segment fault |
| dseg_o | output | 1 | Data segment fault |
| fault_addr_o | output | EA_W | Captured address of a data segment fault |
| bypass_o | output | 1 | Real-mode bypass taken |
| raddr_o | output | EA_W | Bypass real address |
| perm_o | output | 3 | Granted read/write/execute for a bypass |
| proc_run_o | output | 1 | Process-scoped walk needed |
| part_run_o | output | 1 | Partition-scoped walk needed |

## Verification
A wrong quadrant decode or legality rule shows up on the ID or fault outputs in the done cycle of the very request that used it. A wrong mode precedence shows up there too, for example the reserved field being checked ahead of the bypass. The sweep covers every combination of quadrant, mode, relocation, access kind, reserved-field content and partition-register zero/nonzero, so every branch of the decode is compared in its done cycle. A register that loads without a strobe, or that clears early, is caught in the idle cycle after each done. In that cycle the inputs are scrambled while the outputs must stay as they were.

// File: rtl/eaq_pkg.sv
package eaq_pkg;
   typedef enum logic [1:0] {
      ACC_LOAD  = 2'b00,
      ACC_STORE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_SPARE = 2'b11
   } acc_e;

   typedef enum logic [1:0] {
      QUAD_0 = 2'd0,
      QUAD_1 = 2'd1,
      QUAD_2 = 2'd2,
      QUAD_3 = 2'd3
   } quad_e;

   localparam logic [2:0] PERM_NONE = 3'b000;
   localparam logic [2:0] PERM_RWX  = 3'b111;
endpackage

// File: rtl/eaq_quadrant.sv
module eaq_quadrant
   import eaq_pkg::*;
#(
   parameter int HI_W   = 12,
   parameter int LPID_W = 12,
   parameter int PID_W  = 20
) (
   input  logic [HI_W-1:0]   hi_i,
   input  logic              hv_i,
   input  logic [LPID_W-1:0] lpid_reg_i,
   input  logic [PID_W-1:0]  pid_reg_i,
   output logic              legal_o,
   output logic [LPID_W-1:0] lpid_o,
   output logic [PID_W-1:0]  pid_o
);
   quad_e quad;
   logic  rsv_clear;
   logic  quad_ok;

   assign quad = quad_e'(hi_i[HI_W-1 -: 2]);

   generate
      if (HI_W > 2) begin : g_rsv
         assign rsv_clear = ~|hi_i[HI_W-3:0];
      end else begin : g_no_rsv
         assign rsv_clear = 1'b1;
      end
   endgenerate

   always_comb begin
      quad_ok = 1'b1;
      lpid_o  = '0;
      pid_o   = '0;
      if (hv_i) begin
         unique case (quad)
            QUAD_0: pid_o = pid_reg_i;
            QUAD_1: begin lpid_o = lpid_reg_i; pid_o = pid_reg_i; end
            QUAD_2: lpid_o = lpid_reg_i;
            QUAD_3: ;
         endcase
      end else begin
         unique case (quad)
            QUAD_0: begin lpid_o = lpid_reg_i; pid_o = pid_reg_i; end
            QUAD_1, QUAD_2: quad_ok = 1'b0;
            QUAD_3: lpid_o = lpid_reg_i;
         endcase
      end
      if (!(quad_ok && rsv_clear)) begin
         lpid_o = '0;
         pid_o  = '0;
      end
   end

   assign legal_o = quad_ok & rsv_clear;
endmodule

// File: rtl/eaq_realmode.sv
module eaq_realmode #(
   parameter int EA_W      = 64,
   parameter bit OFFSET_EN = 1'b1
) (
   input  logic [EA_W-1:0] ea_i,
   input  logic [EA_W-1:0] rmor_i,
   output logic [EA_W-1:0] raddr_o
);
   localparam int KEEP_W = EA_W - 4;

   logic [EA_W-1:0] stripped;
   assign stripped = {4'b0000, ea_i[KEEP_W-1:0]};

   generate
      if (OFFSET_EN) begin : g_offset
         assign raddr_o = ea_i[EA_W-1] ? stripped : (stripped | rmor_i);
      end else begin : g_plain
         assign raddr_o = stripped;
      end
   endgenerate
endmodule

// File: rtl/eaq_outreg.sv
module eaq_outreg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o,
   output logic         done_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o    <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= load_i;
         if (load_i) q_o <= d_i;
      end
   end

   // R2
   stable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(q_o));
endmodule

// File: rtl/ea_qualifier.sv
module ea_qualifier
   import eaq_pkg::*;
#(
   parameter int EA_W      = 64,
   parameter int VA_BITS   = 52,
   parameter int LPID_W    = 12,
   parameter int PID_W     = 20,
   parameter bit OFFSET_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [EA_W-1:0]   ea_i,
   input  logic [1:0]        acc_i,
   input  logic              hv_i,
   input  logic              reloc_i,
   input  logic [LPID_W-1:0] lpid_reg_i,
   input  logic [PID_W-1:0]  pid_reg_i,
   input  logic [EA_W-1:0]   rmor_i,
   output logic              done_o,
   output logic [LPID_W-1:0] lpid_o,
   output logic [PID_W-1:0]  pid_o,
   output logic              iseg_o,
   output logic              dseg_o,
   output logic [EA_W-1:0]   fault_addr_o,
   output logic              bypass_o,
   output logic [EA_W-1:0]   raddr_o,
   output logic [2:0]        perm_o,
   output logic              proc_run_o,
   output logic              part_run_o
);
   localparam int HI_W  = EA_W - VA_BITS;
   localparam int PKT_W = LPID_W + PID_W + 2 + EA_W + 1 + EA_W + 3 + 2;

   generate
      if (HI_W < 2) begin : g_bad_va
         $error("VA_BITS must leave room for the quadrant bits");
      end
      if (EA_W < 8) begin : g_bad_ea
         $error("EA_W too narrow");
      end
      if (LPID_W < 1 || PID_W < 1) begin : g_bad_id
         $error("ID widths must be positive");
      end
   endgenerate

   logic              legal_c;
   logic [LPID_W-1:0] lpid_c;
   logic [PID_W-1:0]  pid_c;
   logic [EA_W-1:0]   real_c;

   eaq_quadrant #(.HI_W(HI_W), .LPID_W(LPID_W), .PID_W(PID_W)) quad_i (
      .hi_i       (ea_i[EA_W-1:VA_BITS]),
      .hv_i       (hv_i),
      .lpid_reg_i (lpid_reg_i),
      .pid_reg_i  (pid_reg_i),
      .legal_o    (legal_c),
      .lpid_o     (lpid_c),
      .pid_o      (pid_c)
   );

   eaq_realmode #(.EA_W(EA_W), .OFFSET_EN(OFFSET_EN)) real_i (
      .ea_i    (ea_i),
      .rmor_i  (rmor_i),
      .raddr_o (real_c)
   );

   logic bypass_c, fault_c, qual_c, fetch_c;
   logic iseg_c, dseg_c, proc_c, part_c;
   logic [LPID_W-1:0] lpid_n;
   logic [PID_W-1:0]  pid_n;
   logic [EA_W-1:0]   faddr_n, raddr_n;
   logic [2:0]        perm_n;

   always_comb begin
      bypass_c = hv_i & ~reloc_i;
      fault_c  = ~bypass_c & ~legal_c;
      qual_c   = ~bypass_c & legal_c;
      fetch_c  = (acc_e'(acc_i) == ACC_FETCH);
      iseg_c   = fault_c & fetch_c;
      dseg_c   = fault_c & ~fetch_c;
      lpid_n   = qual_c ? lpid_c : '0;
      pid_n    = qual_c ? pid_c  : '0;
      proc_c   = qual_c & reloc_i;
      part_c   = qual_c & ((|lpid_c) | ~hv_i);
      faddr_n  = dseg_c ? ea_i : '0;
      raddr_n  = bypass_c ? real_c : '0;
      perm_n   = bypass_c ? PERM_RWX : PERM_NONE;
   end

   logic [PKT_W-1:0] pkt_d, pkt_q;
   assign pkt_d = {lpid_n, pid_n, iseg_c, dseg_c, faddr_n, bypass_c,
                   raddr_n, perm_n, proc_c, part_c};

   eaq_outreg #(.W(PKT_W)) out_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (req_i),
      .d_i    (pkt_d),
      .q_o    (pkt_q),
      .done_o (done_o)
   );

   assign {lpid_o, pid_o, iseg_o, dseg_o, fault_addr_o, bypass_o,
           raddr_o, perm_o, proc_run_o, part_run_o} = pkt_q;

   // R2
   done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> done_o);
   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !done_o);
   // R11
   outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({iseg_o, dseg_o, bypass_o}));
   // R11
   fault_ids_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iseg_o || dseg_o || bypass_o) |->
         (lpid_o == '0 && pid_o == '0 && !proc_run_o && !part_run_o));
   // R6
   fault_addr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && dseg_o) |-> fault_addr_o == $past(ea_i));
   // R8
   perm_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bypass_o |-> perm_o == PERM_NONE);
   // R10
   part_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && part_run_o) |-> (lpid_o != '0 || !$past(hv_i)));
   // R9
   proc_reloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && proc_run_o) |-> $past(reloc_i));
endmodule

// File: tb/ea_qualifier_tb.sv
`timescale 1ns/1ps
module ea_qualifier_tb_top;
   localparam int EA_W = 64, VA_BITS = 52, LPID_W = 12, PID_W = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_i = 1'b0;
   logic [EA_W-1:0] ea_i = '0;
   logic [1:0] acc_i = '0;
   logic hv_i = 1'b0, reloc_i = 1'b0;
   logic [LPID_W-1:0] lpid_reg_i = '0;
   logic [PID_W-1:0] pid_reg_i = '0;
   logic [EA_W-1:0] rmor_i = '0;
   logic done_o, iseg_o, dseg_o, bypass_o, proc_run_o, part_run_o;
   logic [LPID_W-1:0] lpid_o;
   logic [PID_W-1:0] pid_o;
   logic [EA_W-1:0] fault_addr_o, raddr_o;
   logic [2:0] perm_o;

   always #2.5 clk = ~clk;

   ea_qualifier #(.EA_W(EA_W), .VA_BITS(VA_BITS), .LPID_W(LPID_W),
                  .PID_W(PID_W), .OFFSET_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .ea_i(ea_i), .acc_i(acc_i),
      .hv_i(hv_i), .reloc_i(reloc_i), .lpid_reg_i(lpid_reg_i),
      .pid_reg_i(pid_reg_i), .rmor_i(rmor_i), .done_o(done_o),
      .lpid_o(lpid_o), .pid_o(pid_o), .iseg_o(iseg_o), .dseg_o(dseg_o),
      .fault_addr_o(fault_addr_o), .bypass_o(bypass_o), .raddr_o(raddr_o),
      .perm_o(perm_o), .proc_run_o(proc_run_o), .part_run_o(part_run_o));

   int checks = 0, fails = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input logic [EA_W-1:0] act,
                      input logic [EA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      logic [EA_W-1:0] snap_f, snap_r;
      logic [LPID_W-1:0] snap_l;
      logic [PID_W-1:0] snap_p;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 done", done_o, 0);
      chk("R1 ids", {lpid_o, pid_o}, 0);
      chk("R1 flags", {iseg_o, dseg_o, bypass_o, proc_run_o, part_run_o, perm_o}, 0);
      chk("R1 addrs", fault_addr_o | raddr_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", {done_o, lpid_o, pid_o}, 0);

      rmor_i = 64'h0000_0000_8000_0000;
      pid_reg_i = 20'hA5C3E;
      for (int hv = 0; hv < 2; hv++)
      for (int rl = 0; rl < 2; rl++)
      for (int q = 0; q < 4; q++)
      for (int ac = 0; ac < 3; ac++)
      for (int lz = 0; lz < 2; lz++)
      for (int rs = 0; rs < 2; rs++) begin
         logic [EA_W-1:0] ea;
         logic [LPID_W-1:0] lp;
         logic byp, flt, qual, fetch;
         logic [LPID_W-1:0] el;
         logic [PID_W-1:0] ep;
         logic [EA_W-1:0] er;
         lp = lz ? 12'h3B7 : 12'h000;
         ea = {q[1:0], 10'h000, 52'h3_1234_5678_9ABC ^ 52'(q * 977 + ac * 31)};
         if (rs) ea[VA_BITS + 3] = 1'b1;
         // expected outcome from the requirements
         byp = (hv == 1) && (rl == 0);                              // R7
         flt = !byp && ((rs == 1) || (hv == 0 && (q == 1 || q == 2))); // R3 R5
         qual = !byp && !flt;
         fetch = (ac == 2);
         el = '0; ep = '0;
         if (qual) begin
            if (hv == 1) begin                                      // R4
               el = (q == 1 || q == 2) ? lp : '0;
               ep = (q == 0 || q == 1) ? pid_reg_i : '0;
            end else begin                                          // R5
               el = lp;
               ep = (q == 0) ? pid_reg_i : '0;
            end
         end
         er = byp ? ((ea & 64'h0FFF_FFFF_FFFF_FFFF) | (ea[63] ? 64'h0 : rmor_i)) : '0;

         @(negedge clk);
         ea_i = ea; acc_i = ac[1:0]; hv_i = hv[0]; reloc_i = rl[0];
         lpid_reg_i = lp; req_i = 1'b1;
         @(negedge clk);
         req_i = 1'b0;
         chk("R2 done high", done_o, 1);
         chk("R4 R5 lpid", lpid_o, el);
         chk("R4 R5 pid", pid_o, ep);
         chk("R3 R6 iseg", iseg_o, flt && fetch);
         chk("R3 R6 dseg", dseg_o, flt && !fetch);
         chk("R6 fault addr", fault_addr_o, (flt && !fetch) ? ea : 0);
         chk("R7 bypass", bypass_o, byp);
         chk("R7 raddr", raddr_o, er);
         chk("R8 perm", perm_o, byp ? 3'b111 : 3'b000);
         chk("R9 proc run", proc_run_o, qual && rl == 1);
         chk("R10 part run", part_run_o, qual && (el != 0 || hv == 0));
         chk("R11 exclusive", {1'b0, flt, byp, qual} == 4'b0001 ||
             {1'b0, flt, byp, qual} == 4'b0010 || {1'b0, flt, byp, qual} == 4'b0100, 1);
         snap_f = fault_addr_o; snap_r = raddr_o; snap_l = lpid_o; snap_p = pid_o;
         // scramble inputs with no strobe
         ea_i = ~ea; hv_i = ~hv_i; reloc_i = ~reloc_i; lpid_reg_i = ~lp;
         @(negedge clk);
         chk("R2 done low", done_o, 0);
         chk("R2 hold", {snap_l, snap_p} ^ {lpid_o, pid_o}, 0);
         chk("R2 hold addr", (snap_f ^ fault_addr_o) | (snap_r ^ raddr_o), 0);
      end
      finished = 1'b1;
      summary();
   end
endmodule